// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent down-counters that are programmed through a byte-wide write port. Each counter advances once for every cycle in which the count enable input is high, so the enable carries the fixed input counting rate. A running channel drives a square wave whose period is its programmed divisor. A typical use is one channel producing the periodic request pulse train for a DRAM refresh controller.

Software first writes a command byte. The command names a channel and sets how the 16-bit divisor arrives over the 8-bit port. It also sets the operating mode and chooses between binary and BCD counting. The divisor bytes then go to that channel's data address. When the low byte and the high byte are both expected, only the second write moves the divisor into the counter. The first write is held aside until then.

Each channel has two small state machines. The byte loader has states LD_LOW and LD_HIGH. In low/high access, a data write in LD_LOW stores the byte and moves to LD_HIGH. A data write in LD_HIGH commits the divisor and returns to LD_LOW. A command write for the channel forces LD_LOW. Single-byte accesses commit on every data write and stay in LD_LOW. The counter has states CS_STOP and CS_RUN. A command write moves it to CS_STOP. A commit moves it to CS_RUN when the mode is square wave, and to CS_STOP otherwise. While in CS_RUN, an enabled cycle counts down, and the count reloads from the divisor after it reaches one.

Top module: `tmr_interval3`

## Requirements
- R1: A write to address 3 is a command. Addresses 0, 1 and 2 are the data registers of channels 0, 1 and 2. Command bits 7:6 select the channel (00, 01, 10). A command with bits 7:6 = 11, or with access bits 5:4 = 00, has no effect on any channel.
- R2: After reset every channel is stopped with its output high. Its configuration is low/high access, square-wave mode and binary counting.
- R3: A valid command to a channel stops it: its output is high and stays high. The next data write to that channel is taken as the low byte.
- R4: With access bits 5:4 = 11, the first data write is the low byte and the second is the high byte. Only the high-byte write commits the divisor. A low-byte write alone leaves the running waveform unchanged.
- R5: With access bits 5:4 = 01, each data write commits the divisor {0x00, byte}. With access bits 5:4 = 10, each data write commits {byte, 0x00}.
- R6: In square-wave mode with divisor N, the output is high for ceil(N/2) counting cycles and then low for floor(N/2) counting cycles. This repeats without end. The first high cycle is the cycle after the commit edge. N = 1 gives a steady high output.
- R7: The counter changes only on cycles with cnt_en high. With cnt_en low, the output holds.
- R8: With command bit 0 = 1, the divisor is four BCD digits (bits 15:12 most significant). Each digit counts 9 down to 0 and borrows from the next digit, so the period is the decimal value.
- R9: A divisor of zero gives a period of 65536 in binary and 10000 in BCD.
- R10: Command bits 3:1 equal to 011 or 111 select square-wave mode. Any other value leaves the channel stopped after a commit, with its output held high.
- R11: A commit to a running channel restarts its period at once with the new divisor.
- R12: Programming one channel does not disturb the phase of another running channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counting enable, one pulse per input count period |
| wr_en | input | 1 | Write strobe for the byte port |
| wr_addr | input | 2 | Register address: 0 to 2 data, 3 command |
| wr_data | input | 8 | Write byte |
| ch_out | output | 3 | Square-wave output of each channel |

## Verification
The assertions are checked on every cycle. They keep a running count between one and its reload value, and they require a reload to follow the last count. They require the output to hold on cycles without enable, every BCD digit to stay valid, a stopped channel to show a high output, and two commits in low/high access never to be back to back. The exact high and low phase lengths can only be shown by the bench scenarios. So can the decimal period of BCD divisors and the zero-divisor periods. The same holds for ignored command forms, the low byte having no effect until the high byte arrives, and one channel's phase surviving another channel's programming. The bench sweeps many binary and BCD divisors and compares each output against an arithmetic phase model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef enum logic {
        LD_LOW  = 1'b0,
        LD_HIGH = 1'b1
    } ld_e;

    typedef enum logic {
        CS_STOP = 1'b0,
        CS_RUN  = 1'b1
    } cs_e;

    // Field order matches command byte bits 5:0
    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } cfg_t;

endpackage

// File: rtl/tmr_byte_loader.sv
module tmr_byte_loader
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr_i,
    input  cfg_t                cmd_i,
    input  logic                data_wr_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                commit_o,
    output logic [2*BYTE_W-1:0] div_o,
    output logic                bcd_o,
    output logic                sq_o
);

    cfg_t              cfg_q;
    ld_e               ld_q, ld_d;
    logic [BYTE_W-1:0] lo_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= LD_LOW;
        else        ld_q <= ld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{acc: ACC_LOHI, mode: 3'b011, bcd: 1'b0};
            lo_q  <= '0;
        end else begin
            if (cmd_wr_i) cfg_q <= cmd_i;
            if (data_wr_i && cfg_q.acc == ACC_LOHI && ld_q == LD_LOW) lo_q <= data_i;
        end
    end

    // transitions
    always_comb begin
        ld_d = ld_q;
        if (cmd_wr_i) begin
            ld_d = LD_LOW;
        end else if (data_wr_i && cfg_q.acc == ACC_LOHI) begin
            unique case (ld_q)
                LD_LOW:  ld_d = LD_HIGH;
                LD_HIGH: ld_d = LD_LOW;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        div_o    = '0;
        unique case (cfg_q.acc)
            ACC_LO: begin
                commit_o = data_wr_i;
                div_o    = {{BYTE_W{1'b0}}, data_i};
            end
            ACC_HI: begin
                commit_o = data_wr_i;
                div_o    = {data_i, {BYTE_W{1'b0}}};
            end
            ACC_LOHI: begin
                commit_o = data_wr_i && (ld_q == LD_HIGH);
                div_o    = {data_i, lo_q};
            end
            default: ;
        endcase
    end

    assign bcd_o = cfg_q.bcd;
    assign sq_o  = (cfg_q.mode == 3'b011) || (cfg_q.mode == 3'b111);

    assert_lohi_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && cfg_q.acc == ACC_LOHI) |=> !commit_o);

    assert_cmd_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> (!commit_o || cfg_q.acc != ACC_LOHI));

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic             bcd_i,
    input  logic             sq_i,
    output logic             out_o
);

    localparam int VAL_W  = CNT_W + 1;
    localparam int DIGITS = CNT_W / 4;
    // 2^CNT_W in binary is also digit 1 above the top BCD digit
    localparam logic [VAL_W-1:0] FULL = VAL_W'(1) << CNT_W;

    function automatic logic [VAL_W-1:0] bcd_dec(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] r;
        logic             br;
        r  = v;
        br = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (br) begin
                if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
                else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    br          = 1'b0;
                end
            end
        end
        if (br) r[CNT_W] = 1'b0;
        return r;
    endfunction

    function automatic logic [VAL_W-1:0] bcd_half(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] r;
        r = '0;
        for (int i = 0; i < DIGITS; i++)
            r[4*i +: 4] = {1'b0, v[4*i+1 +: 3]} + (v[4*i+4] ? 4'd5 : 4'd0);
        return r;
    endfunction

    function automatic logic bcd_ok(input logic [VAL_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    cs_e              cs_q, cs_d;
    logic [VAL_W-1:0] cnt_q, cnt_d, reload_q, half_q, new_reload, new_half;
    logic             bcd_q;

    assign new_reload = (div_i == '0) ? FULL : {1'b0, div_i};
    assign new_half   = bcd_i ? bcd_half(new_reload) : (new_reload >> 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= CS_STOP;
            cnt_q    <= VAL_W'(1);
            reload_q <= VAL_W'(1);
            half_q   <= '0;
            bcd_q    <= 1'b0;
        end else begin
            cs_q  <= cs_d;
            cnt_q <= cnt_d;
            if (commit_i && !stop_i) begin
                reload_q <= new_reload;
                half_q   <= new_half;
                bcd_q    <= bcd_i;
            end
        end
    end

    // transitions
    always_comb begin
        cs_d  = cs_q;
        cnt_d = cnt_q;
        if (stop_i) begin
            cs_d = CS_STOP;
        end else if (commit_i) begin
            cs_d  = sq_i ? CS_RUN : CS_STOP;
            cnt_d = new_reload;
        end else begin
            unique case (cs_q)
                CS_STOP: ;
                CS_RUN: if (tick_i) begin
                    if (cnt_q == VAL_W'(1)) cnt_d = reload_q;
                    else if (bcd_q)         cnt_d = bcd_dec(cnt_q);
                    else                    cnt_d = cnt_q - VAL_W'(1);
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        out_o = (cs_q == CS_STOP) || (cnt_q > half_q);
    end

    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_RUN) |-> (cnt_q >= VAL_W'(1) && cnt_q <= reload_q));

    assert_reload_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_RUN && tick_i && cnt_q == VAL_W'(1) && !commit_i && !stop_i)
        |=> (cnt_q == $past(reload_q)));

    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !commit_i && !stop_i) |=> $stable(out_o));

    assert_bcd_digits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_RUN && bcd_q) |-> bcd_ok(cnt_q));

    assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> out_o);

endmodule

// File: rtl/tmr_interval3.sv
module tmr_interval3
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] ch_out
);

    localparam int         CNT_W    = 2 * BYTE_W;
    localparam logic [1:0] CMD_ADDR = 2'd3;

    logic cmd_hit;
    cfg_t cmd_cfg;
    logic [NUM_CH-1:0] cmd_vec;

    assign cmd_hit = wr_en && (wr_addr == CMD_ADDR);
    assign cmd_cfg = cfg_t'(wr_data[5:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             commit, bcd, sq, data_hit;
        logic [CNT_W-1:0] div;

        assign cmd_vec[g] = cmd_hit && (wr_data[7:6] == 2'(g)) && (cmd_cfg.acc != ACC_LATCH);
        assign data_hit   = wr_en && (wr_addr == 2'(g));

        tmr_byte_loader #(.BYTE_W(BYTE_W)) u_load (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_wr_i  (cmd_vec[g]),
            .cmd_i     (cmd_cfg),
            .data_wr_i (data_hit),
            .data_i    (wr_data),
            .commit_o  (commit),
            .div_o     (div),
            .bcd_o     (bcd),
            .sq_o      (sq)
        );

        tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (cnt_en),
            .stop_i   (cmd_vec[g]),
            .commit_i (commit),
            .div_i    (div),
            .bcd_i    (bcd),
            .sq_i     (sq),
            .out_o    (ch_out[g])
        );
    end

    assert_single_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_vec));

endmodule

// File: tb/tmr_interval3_tb.sv
module tmr_interval3_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] ch_out;

    int n_chk = 0;
    int n_fail = 0;
    int k0, k1, k2;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_interval3 u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_out  (ch_out)
    );

    task automatic note(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a sampling point just after a negedge; consumes one posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int expv(input int kk, input int n);
        return ((kk % n) < (n + 1) / 2) ? 1 : 0;
    endfunction

    function automatic int bcd_val(input logic [15:0] v);
        return v[3:0] + 10 * v[7:4] + 100 * v[11:8] + 1000 * v[15:12];
    endfunction

    task automatic watch(input int ch, input int n, input int samples, input string req,
                         inout int kk, input bit gap);
        bit bad = 1'b0;
        int act = 0, exp = 0;
        for (int s = 0; s < samples; s++) begin
            if (int'(ch_out[ch]) != expv(kk, n) && !bad) begin
                bad = 1'b1; act = int'(ch_out[ch]); exp = expv(kk, n);
            end
            cnt_en = gap ? (s % 2 == 0) : 1'b1;
            @(posedge clk); @(negedge clk);
            if (cnt_en) kk++;
        end
        cnt_en = 1'b1;
        note(!bad, req, act, exp);
    endtask

    task automatic hold_high(input int ch, input int samples, input string req);
        bit bad = 1'b0;
        for (int s = 0; s < samples; s++) begin
            if (ch_out[ch] !== 1'b1) bad = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        note(!bad, req, bad ? 0 : 1, 1);
    endtask

    initial begin
        #1900000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int bin_list[12] = '{1, 2, 3, 4, 5, 6, 7, 9, 16, 255, 256, 1000};
        logic [15:0] bcd_list[7] = '{16'h0001, 16'h0002, 16'h0009, 16'h0010,
                                     16'h0015, 16'h0100, 16'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        note(ch_out == 3'b111, "R2 reset outputs", int'(ch_out), 7);
        // R2: default low/high binary square config without any command
        wr(2'd1, 8'd4); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 4, 10, "R2 default config", k1, 1'b0);

        // R6: binary sweep on channel 1, command 0x76
        foreach (bin_list[i]) begin
            wr(2'd3, 8'h76);
            wr(2'd1, bin_list[i][7:0]); wr(2'd1, bin_list[i][15:8]); k1 = 0;
            watch(1, bin_list[i], 2 * bin_list[i] + 4, "R6 binary square wave", k1, 1'b0);
        end

        // R8: BCD sweep on channel 0, command 0x37
        foreach (bcd_list[i]) begin
            wr(2'd3, 8'h37);
            wr(2'd0, bcd_list[i][7:0]); wr(2'd0, bcd_list[i][15:8]); k0 = 0;
            watch(0, bcd_val(bcd_list[i]), 2 * bcd_val(bcd_list[i]) + 4, "R8 BCD period", k0, 1'b0);
        end

        // R7: gapped enable on channel 2, command 0xB6
        wr(2'd3, 8'hB6); wr(2'd2, 8'd5); wr(2'd2, 8'd0); k2 = 0;
        watch(2, 5, 30, "R7 gapped enable", k2, 1'b1);
        wr(2'd3, 8'hB6); wr(2'd2, 8'd8); wr(2'd2, 8'd0); k2 = 0;
        watch(2, 8, 40, "R7 gapped enable even", k2, 1'b1);

        // R5: single-byte access
        wr(2'd3, 8'h96); wr(2'd2, 8'd9); k2 = 0;
        watch(2, 9, 22, "R5 low-only access", k2, 1'b0);
        wr(2'd2, 8'd3); k2 = 0;
        watch(2, 3, 10, "R5 low-only repeat commit", k2, 1'b0);
        wr(2'd3, 8'hA6); wr(2'd2, 8'h01); k2 = 0;
        watch(2, 256, 520, "R5 high-only access", k2, 1'b0);

        // R4 and R11: low byte alone keeps old waveform, high byte restarts
        wr(2'd3, 8'h76); wr(2'd1, 8'd6); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 6, 5, "R4 before low byte", k1, 1'b0);
        wr(2'd1, 8'd3); k1++;
        watch(1, 6, 8, "R4 low byte no commit", k1, 1'b0);
        wr(2'd1, 8'd0); k1 = 0;
        watch(1, 3, 10, "R11 restart on high byte", k1, 1'b0);

        // R1: ignored commands while channel 1 runs with period 3
        wr(2'd3, 8'hF6); k1++;
        wr(2'd3, 8'h46); k1++;
        watch(1, 3, 12, "R1 ignored commands", k1, 1'b0);

        // R3: command stops channel, pointer back to low byte
        wr(2'd3, 8'h76);
        hold_high(1, 12, "R3 command stops channel");
        wr(2'd1, 8'h33);
        wr(2'd3, 8'h76);
        wr(2'd1, 8'd5); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 5, 14, "R3 pointer reset", k1, 1'b0);

        // R10: non-square modes stay high, mode 111 squares
        wr(2'd3, 8'h70); wr(2'd1, 8'd4); wr(2'd1, 8'd0);
        hold_high(1, 12, "R10 mode 000 held high");
        wr(2'd3, 8'h7A); wr(2'd1, 8'd4); wr(2'd1, 8'd0);
        hold_high(1, 12, "R10 mode 101 held high");
        wr(2'd3, 8'h7E); wr(2'd1, 8'd4); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 4, 12, "R10 mode 111 square", k1, 1'b0);

        // R12: programming channel 2 keeps channel 0 phase
        wr(2'd3, 8'h36); wr(2'd0, 8'd5); wr(2'd0, 8'd0); k0 = 0;
        wr(2'd3, 8'h96); k0++;
        wr(2'd2, 8'd3);  k0++;
        watch(0, 5, 20, "R12 channel independence", k0, 1'b0);

        // R9: zero divisor
        wr(2'd3, 8'h76); wr(2'd1, 8'd0); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 65536, 32772, "R9 binary zero divisor", k1, 1'b0);
        wr(2'd3, 8'h77); wr(2'd1, 8'd0); wr(2'd1, 8'd0); k1 = 0;
        watch(1, 10000, 10004, "R9 BCD zero divisor", k1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule